// File: doc/BRIEF.md
# Three-Plane Graphics Write Logic Unit

This unit sits between a CPU bus and a bitmap graphics store made of three colour planes (red, green, blue). A group of eight write-only I/O locations, placed at a configurable base, holds a mode byte and one pixel mask per plane. Two of those locations act as strobes that switch a graphics window into the top quarter of the 64 KB CPU memory space and switch it out again. While the window is in, `winHit` tells the surrounding memory decode to give way.

Every CPU memory write that lands in the window becomes a read-modify-write on the plane or planes the mode byte names. The old byte is combined with the CPU data through one of four raster operators, and only the pixels whose mask bit is set take the result. In indirect mode one CPU write updates all three planes, each under its own mask. CPU reads in the window return the plane chosen by the read field one cycle later. The plane stores are modelled as synchronous RAMs. The logic that scans the planes out to a display is not part of this unit.

Top module: `gfx_plane_rop_unit`

## Requirements
- R1: After reset the mode byte and all three masks are zero, the window is unmapped, and `gfxOutEn`, `txtOutEn`, `winMapped` and `memRdValid` are 0.
- R2: An I/O write is taken only when `ioAddr[7:3]` equals `ioBase`; `ioAddr[2:0]` is the offset: 0 = mode, 1 = red mask, 2 = green mask, 3 = blue mask. Writes at offsets 6 and 7, or at any address outside the eight, change nothing.
- R3: A write at offset 4 maps the window and a write at offset 5 unmaps it, both from the next cycle. `winHit` is high exactly when the window is mapped and `memAddr[15:14]` is 2'b11. Memory accesses with `winHit` low are ignored.
- R4: `gfxOutEn` follows mode bit 5 and `txtOutEn` follows mode bit 4.
- R5: Mode bits 7:6 choose the operator applied to old byte and CPU data: 00 OR, 01 AND, 10 NAND, 11 XOR.
- R6: For each plane written, the new byte is the operator result where the plane's mask bit is 1 and the old byte where it is 0.
- R7: Mode bits 3:2 = 00, 01, 10 write only the red, green or blue plane respectively; the other two planes keep their contents.
- R8: Mode bits 3:2 = 11 (indirect) writes all three planes with one CPU write, each under its own mask.
- R9: A read in the window sets `memRdValid` in the next cycle with the byte of the plane chosen by mode bits 1:0 (00 red, 01 green, 10 blue); code 11 returns 8'hFF.
- R10: An access to the byte address written in the previous cycle sees the new contents, with no idle cycle needed.
- R11: An I/O write in the same cycle as a memory access does not affect that access, which uses the settings in force before the cycle. When `memWrEn` and `memRdEn` are both high, only the write is performed and no read response follows.
- R12: The byte address inside each plane is `memAddr[PLANE_AW-1:0]`; window address bits above it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioWrEn | input | 1 | I/O write strobe |
| ioAddr | input | IO_AW | I/O address |
| ioWrData | input | 8 | I/O write data |
| ioBase | input | IO_AW-3 | Upper I/O address bits selecting the register group |
| memWrEn | input | 1 | CPU memory write strobe |
| memRdEn | input | 1 | CPU memory read strobe |
| memAddr | input | ADDR_W | CPU memory address |
| memWrData | input | 8 | CPU memory write data |
| memRdData | output | 8 | Read data, valid with memRdValid |
| memRdValid | output | 1 | Read response, one cycle after the request |
| winHit | output | 1 | Current address falls in the mapped window |
| winMapped | output | 1 | Window is mapped |
| gfxOutEn | output | 1 | Graphics output enable from the mode byte |
| txtOutEn | output | 1 | Text output enable from the mode byte |

## Verification
The collision of interest is a register write and a plane access in the same cycle: a mode, mask or map strobe arrives while a memory write or read is being accepted. The bench provokes it directly and through random mixing of I/O and memory traffic, and its model applies the memory operation with the old settings before updating them, so any leak of the new operator, mask, target, read field or mapping into that access shows up as a wrong plane byte on a later read or a wrong `winHit`. Back-to-back writes and reads to a small address set, with aliased upper bits, also push the forwarding path between the write stage and the next access.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int PLANES = 3;
  localparam int BYTE_W = 8;
  localparam logic [1:0] TGT_ALL = 2'b11;

  typedef enum logic [1:0] {
    ROP_OR   = 2'b00,
    ROP_AND  = 2'b01,
    ROP_NAND = 2'b10,
    ROP_XOR  = 2'b11
  } ropT;

  // Strobes and settings handed from control to datapath for one access.
  typedef struct packed {
    logic                             wrGo;
    logic                             rdGo;
    ropT                              op;
    logic [1:0]                       target;
    logic [1:0]                       rdSel;
    logic [PLANES-1:0][BYTE_W-1:0]    mask;
  } accessT;

  function automatic logic [BYTE_W-1:0] ropApply(ropT op, logic [BYTE_W-1:0] a,
                                                 logic [BYTE_W-1:0] b);
    case (op)
      ROP_OR:   return a | b;
      ROP_AND:  return a & b;
      ROP_NAND: return ~(a & b);
      default:  return a ^ b;
    endcase
  endfunction
endpackage

// File: rtl/gfx_ctrl.sv
module gfx_ctrl
  import gfx_pkg::*;
#(
  parameter int IO_AW  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic [IO_AW-4:0]  ioBase,
  input  logic              memWrEn,
  input  logic              memRdEn,
  input  logic [1:0]        memTop,
  output accessT            acc,
  output logic              winHit,
  output logic              winMapped,
  output logic              gfxOutEn,
  output logic              txtOutEn
);
  logic [7:0]                    modeQ;
  logic [PLANES-1:0][BYTE_W-1:0] maskQ;
  logic                          mappedQ;
  logic                          ioSel;
  logic [2:0]                    ioOff;

  assign ioSel = ioWrEn && (ioAddr[IO_AW-1:3] == ioBase);
  assign ioOff = ioAddr[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      maskQ   <= '0;
      mappedQ <= 1'b0;
    end else if (ioSel) begin
      case (ioOff)
        3'd0: modeQ    <= ioWrData;
        3'd1: maskQ[0] <= ioWrData;
        3'd2: maskQ[1] <= ioWrData;
        3'd3: maskQ[2] <= ioWrData;
        3'd4: mappedQ  <= 1'b1;
        3'd5: mappedQ  <= 1'b0;
        default: ;
      endcase
    end
  end

  assign winHit    = mappedQ && (memTop == 2'b11);
  assign winMapped = mappedQ;
  assign gfxOutEn  = modeQ[5];
  assign txtOutEn  = modeQ[4];

  always_comb begin
    acc.wrGo   = memWrEn && winHit;
    acc.rdGo   = memRdEn && !memWrEn && winHit;
    acc.op     = ropT'(modeQ[7:6]);
    acc.target = modeQ[3:2];
    acc.rdSel  = modeQ[1:0];
    acc.mask   = maskQ;
  end

  AST_MAP_ON: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && ioOff == 3'd4) |=> winMapped); // R3
  AST_MAP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && ioOff == 3'd5) |=> !winMapped); // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ioSel && ioOff == 3'd0) |=> $stable(modeQ)); // R2
endmodule

// File: rtl/gfx_datapath.sv
module gfx_datapath
  import gfx_pkg::*;
#(
  parameter int PLANE_AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  accessT              acc,
  input  logic [PLANE_AW-1:0] addr,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  output logic                rdValid
);
  localparam int DEPTH = 1 << PLANE_AW;

  logic                          s1Wr, s1Rd;
  logic [PLANE_AW-1:0]           s1Addr;
  logic [BYTE_W-1:0]             s1Data;
  ropT                           s1Op;
  logic [1:0]                    s1Tgt, s1RdSel;
  logic [PLANES-1:0][BYTE_W-1:0] s1Mask;

  logic [PLANES-1:0]             planeWe, wbWe;
  logic [PLANE_AW-1:0]           wbAddr;
  logic [PLANES-1:0][BYTE_W-1:0] wbData, oldByte, newByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Wr <= 1'b0;
      s1Rd <= 1'b0;
      wbWe <= '0;
    end else begin
      s1Wr <= acc.wrGo;
      s1Rd <= acc.rdGo;
      wbWe <= planeWe;
    end
  end

  always_ff @(posedge clk) begin
    if (acc.wrGo || acc.rdGo) begin
      s1Addr  <= addr;
      s1Data  <= wrData;
      s1Op    <= acc.op;
      s1Tgt   <= acc.target;
      s1RdSel <= acc.rdSel;
      s1Mask  <= acc.mask;
    end
    wbAddr <= s1Addr;
    wbData <= newByte;
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] store [DEPTH];
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (planeWe[p]) store[s1Addr] <= newByte[p];
      if (acc.wrGo || acc.rdGo) q <= store[addr];
    end

    assign oldByte[p] = (wbWe[p] && wbAddr == s1Addr) ? wbData[p] : q;
    assign newByte[p] = oldByte[p] ^
      ((ropApply(s1Op, oldByte[p], s1Data) ^ oldByte[p]) & s1Mask[p]);
    assign planeWe[p] = s1Wr && (s1Tgt == 2'(p) || s1Tgt == TGT_ALL);

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      planeWe[p] |-> (((newByte[p] ^ oldByte[p]) & ~s1Mask[p]) == '0)); // R6
  end

  always_comb begin
    case (s1RdSel)
      2'd0:    rdData = oldByte[0];
      2'd1:    rdData = oldByte[1];
      2'd2:    rdData = oldByte[2];
      default: rdData = '1;
    endcase
  end
  assign rdValid = s1Rd;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    acc.rdGo |=> rdValid); // R9
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(acc.rdGo)); // R9
  AST_SINGLE_TGT: assert property (@(posedge clk) disable iff (!rstN)
    (s1Wr && s1Tgt != TGT_ALL) |-> ($countones(planeWe) == 1)); // R7
  AST_ALL_TGT: assert property (@(posedge clk) disable iff (!rstN)
    (s1Wr && s1Tgt == TGT_ALL) |-> (planeWe == '1)); // R8
endmodule

// File: rtl/gfx_plane_rop_unit.sv
module gfx_plane_rop_unit
  import gfx_pkg::*;
#(
  parameter int IO_AW    = 8,
  parameter int ADDR_W   = 16,
  parameter int PLANE_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic [IO_AW-4:0]  ioBase,
  input  logic              memWrEn,
  input  logic              memRdEn,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWrData,
  output logic [7:0]        memRdData,
  output logic              memRdValid,
  output logic              winHit,
  output logic              winMapped,
  output logic              gfxOutEn,
  output logic              txtOutEn
);
  localparam int WIN_LSB = ADDR_W - 2;

  accessT acc;

  if (PLANE_AW < WIN_LSB) begin : g_alias
    logic unusedAliasBits;
    assign unusedAliasBits = ^memAddr[WIN_LSB-1:PLANE_AW];
  end

  gfx_ctrl #(.IO_AW(IO_AW), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioBase(ioBase),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memTop(memAddr[ADDR_W-1:WIN_LSB]),
    .acc(acc), .winHit(winHit), .winMapped(winMapped),
    .gfxOutEn(gfxOutEn), .txtOutEn(txtOutEn)
  );

  gfx_datapath #(.PLANE_AW(PLANE_AW)) dp_i (
    .clk(clk), .rstN(rstN), .acc(acc),
    .addr(memAddr[PLANE_AW-1:0]), .wrData(memWrData),
    .rdData(memRdData), .rdValid(memRdValid)
  );
endmodule

// File: tb/gfx_plane_rop_unit_tb.sv
`timescale 1ns/1ps
module gfx_plane_rop_unit_tb_top;
  localparam logic [4:0] BASE = 5'h1E;

  logic clk = 1'b0, rstN = 1'b0;
  logic ioWrEn = 1'b0, memWrEn = 1'b0, memRdEn = 1'b0;
  logic [7:0] ioAddr = '0, ioWrData = '0, memWrData = '0;
  logic [15:0] memAddr = '0;
  logic [7:0] memRdData;
  logic memRdValid, winHit, winMapped, gfxOutEn, txtOutEn;

  gfx_plane_rop_unit dut_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioBase(BASE), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .memRdValid(memRdValid),
    .winHit(winHit), .winMapped(winMapped), .gfxOutEn(gfxOutEn), .txtOutEn(txtOutEn)
  );

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  logic [7:0] mPlane [3][256];
  logic [7:0] mMode, mMask [3];
  logic mMapped, pendValid;
  logic [7:0] pendData;
  string pendTag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refOp(logic [1:0] op, logic [7:0] a, logic [7:0] b);
    if (op == 2'b00) return a | b;
    if (op == 2'b01) return a & b;
    if (op == 2'b10) return ~(a & b);
    return a ^ b;
  endfunction

  function automatic logic [7:0] refSel(logic [1:0] sel, logic [7:0] a);
    if (sel == 2'b11) return 8'hFF;
    return mPlane[sel][a];
  endfunction

  task automatic modelReset();
    mMode = '0; mMapped = 0; pendValid = 0;
    for (int p = 0; p < 3; p++) mMask[p] = '0;
  endtask

  task automatic step(logic iw, logic [7:0] ia, logic [7:0] id, logic mw, logic mr,
                      logic [15:0] ma, logic [7:0] md, string tag);
    logic hit;
    @(negedge clk);
    chk({pendTag, " valid"}, memRdValid, pendValid);
    if (pendValid) chk({pendTag, " data"}, memRdData, pendData);
    ioWrEn = iw; ioAddr = ia; ioWrData = id;
    memWrEn = mw; memRdEn = mr; memAddr = ma; memWrData = md;
    hit = mMapped && (ma[15:14] == 2'b11);
    #1;
    if (mw || mr) chk("R3 winHit", winHit, hit);
    pendValid = 0;
    if (mw && hit) begin
      for (int p = 0; p < 3; p++)
        if (mMode[3:2] == 2'b11 || mMode[3:2] == 2'(p)) begin
          logic [7:0] o = mPlane[p][ma[7:0]];
          mPlane[p][ma[7:0]] = (refOp(mMode[7:6], o, md) & mMask[p]) | (o & ~mMask[p]);
        end
    end else if (mr && hit) begin
      pendValid = 1; pendData = refSel(mMode[1:0], ma[7:0]); pendTag = tag;
    end
    if (iw && ia[7:3] == BASE) begin
      case (ia[2:0])
        3'd0: mMode = id;
        3'd1: mMask[0] = id;
        3'd2: mMask[1] = id;
        3'd3: mMask[2] = id;
        3'd4: mMapped = 1;
        3'd5: mMapped = 0;
        default: ;
      endcase
    end
  endtask

  task automatic ioW(logic [2:0] off, logic [7:0] d);
    step(1, {BASE, off}, d, 0, 0, 16'h0, 8'h0, "");
  endtask
  task automatic memW(logic [15:0] a, logic [7:0] d);
    step(0, 8'h0, 8'h0, 1, 0, a, d, "");
  endtask
  task automatic memR(logic [15:0] a, string tag);
    step(0, 8'h0, 8'h0, 0, 1, a, 8'h0, tag);
  endtask
  task automatic idle();
    step(0, 8'h0, 8'h0, 0, 0, 16'h0, 8'h0, "idle");
  endtask

  task automatic doReset();
    @(negedge clk);
    ioWrEn = 0; memWrEn = 0; memRdEn = 0; rstN = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 gfxOutEn", gfxOutEn, 0);
    chk("R1 txtOutEn", txtOutEn, 0);
    chk("R1 winMapped", winMapped, 0);
    chk("R1 memRdValid", memRdValid, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < 3; p++) for (int a = 0; a < 256; a++) mPlane[p][a] = 8'h00;
    doReset();
    // clear all planes: indirect AND with zero data, full masks
    ioW(3'd4, 8'h00);
    ioW(3'd0, 8'h4C);
    for (int p = 1; p <= 3; p++) ioW(3'(p), 8'hFF);
    for (int a = 0; a < 256; a++) memW({8'hC0, 8'(a)}, 8'h00);
    idle();
    // R1: reset clears masks (memory kept); unmapped after reset
    doReset();
    memR(16'hC005, "R3 unmapped read");
    ioW(3'd4, 8'h00);
    memW(16'hC005, 8'hFF);
    memR(16'hC005, "R1 masks zero");
    idle();
    // R4
    ioW(3'd0, 8'h30); idle();
    chk("R4 gfxOutEn", gfxOutEn, 1); chk("R4 txtOutEn", txtOutEn, 1);
    ioW(3'd0, 8'h20); idle();
    chk("R4 gfxOutEn", gfxOutEn, 1); chk("R4 txtOutEn", txtOutEn, 0);
    // R2: out-of-range base and offsets 6/7 ignored
    step(1, {BASE ^ 5'h01, 3'd0}, 8'h10, 0, 0, 16'h0, 8'h0, ""); idle();
    chk("R2 foreign base", txtOutEn, 0);
    ioW(3'd6, 8'hFF); ioW(3'd7, 8'hFF); idle();
    chk("R2 offset 6/7", {gfxOutEn, txtOutEn, winMapped}, 3'b101);
    // R5: each operator on red, full mask
    ioW(3'd1, 8'hFF); ioW(3'd2, 8'hFF); ioW(3'd3, 8'hFF);
    for (int op = 0; op < 4; op++) begin
      ioW(3'd0, 8'h00); memW(16'hC010, 8'h00); memW(16'hC010, 8'hA5);
      ioW(3'd0, {2'(op), 6'h00}); memW(16'hC010, 8'h3C);
      memR(16'hC010, "R5 operator");
    end
    // R6: partial mask
    ioW(3'd1, 8'h0F); ioW(3'd0, 8'hC0);
    memW(16'hC020, 8'hFF); memR(16'hC020, "R6 mask");
    // R7: green-only write, other planes kept
    ioW(3'd2, 8'hFF); ioW(3'd0, 8'h04); memW(16'hC020, 8'h81);
    ioW(3'd0, 8'h00); memR(16'hC020, "R7 red kept");
    ioW(3'd0, 8'h01); memR(16'hC020, "R7 green");
    ioW(3'd0, 8'h02); memR(16'hC020, "R7 blue kept");
    // R8: indirect, distinct masks
    ioW(3'd1, 8'hF0); ioW(3'd2, 8'h3C); ioW(3'd3, 8'h01); ioW(3'd0, 8'h0C);
    memW(16'hC030, 8'hFF);
    memR(16'hC030, "R8 red");
    ioW(3'd0, 8'h0D); memR(16'hC030, "R8 green");
    ioW(3'd0, 8'h0E); memR(16'hC030, "R8 blue");
    // R9: read code 11
    ioW(3'd0, 8'h03); memR(16'hC030, "R9 code 11");
    // R10: back-to-back to same address
    ioW(3'd1, 8'hFF); ioW(3'd0, 8'hC0);
    memW(16'hC040, 8'h11); memW(16'hC040, 8'h22); memR(16'hC040, "R10 forward");
    memW(16'hC040, 8'h0F); memR(16'hC040, "R10 forward");
    // R11: I/O write in same cycle as memory write / read
    step(1, {BASE, 3'd0}, 8'h00, 1, 0, 16'hC050, 8'h5A, "");
    memR(16'hC050, "R11 snapshot");
    step(1, {BASE, 3'd0}, 8'h02, 0, 1, 16'hC050, 8'h00, "R11 rd snapshot");
    step(0, 8'h0, 8'h0, 1, 1, 16'hC050, 8'h33, "R11 wr priority");
    ioW(3'd0, 8'h00); memR(16'hC050, "R11 wr priority");
    step(1, {BASE, 3'd5}, 8'h00, 0, 1, 16'hC050, 8'h00, "R11 map snapshot");
    // R3: unmapped accesses ignored
    memW(16'hC050, 8'h00); memR(16'hC050, "R3 unmapped");
    ioW(3'd4, 8'h00);
    memW(16'h4050, 8'hFF); memR(16'h8050, "R3 outside window");
    memR(16'hC050, "R3 unchanged");
    // R12: aliasing of upper window bits
    memW(16'hF160, 8'h77); memR(16'hC060, "R12 alias");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int kind = int'($urandom % 100);
      logic [15:0] ma = {(($urandom % 8) == 0) ? 2'b01 : 2'b11, 6'($urandom), 8'($urandom % 16)};
      if (kind < 15) begin
        logic [2:0] off = 3'($urandom % 8);
        logic [4:0] b = (($urandom % 10) == 0) ? (BASE ^ 5'h03) : BASE;
        if (off == 3'd5 && ($urandom % 4) != 0) off = 3'd4;
        step(1, {b, off}, 8'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
             ma, 8'($urandom), "R5 random collide");
      end else if (kind < 55) memW(ma, 8'($urandom));
      else if (kind < 95) memR(ma, "R5 random read");
      else idle();
    end
    idle(); idle();
    finishRun();
  end
endmodule